// File: doc/BRIEF.md
# Clock Power-Down Sequencer

This block steers a clock generator into and out of its low-power state. A power-down request arrives asynchronously and active low; once it has been brought into the internal CPU-rate clock domain, the block parks every clock output low. Only after the outputs are parked does it drop the enables of the synthesis loops and of the crystal oscillator. With the oscillator off, the internal clock stops. The block then waits for the request to go away.

Leaving the low-power state starts without a clock. The raw request is used directly as an asynchronous wake, so the oscillator enable returns first. The settling wait is then counted on the restarted clock, and a parameter sets its length. Only after the wait are the outputs released. If the request returns during the settling wait, the block goes straight back to parking, and the outputs are never released.

The separate CPU-clock and PCI-clock stop inputs are synchronized in the same way. They only gate their output groups while the outputs are not parked. During power-down they have no effect.

Top module: `clkpd_seq`

## Requirements
- R1: The request `pd_req_n` passes through a two-flop synchronizer on `clk_int`. A low level that has been sampled by only one rising edge does not yet raise `out_hold`.
- R2: On entry, `out_hold` is high for one full cycle while `osc_en` and `pll_en` are still 1. Both enables fall together on the next edge, and neither ever falls unless `out_hold` was high in the previous cycle.
- R3: Once `pd_req_n` is held low, `out_hold` is 1 directly after the second rising edge, which is fewer than three cycles.
- R4: While powered down, `pll_en` is 0 and `out_hold` is 1, and `osc_en` follows the raw `pd_req_n` with no clock edge in between. This is the asynchronous wake.
- R5: After the synchronized request clears in the powered-down state, the loops are re-enabled and `out_hold` stays 1 for exactly `SETTLE_CYCLES` cycles. A release cycle follows, with `out_hold`=0 and `ready`=0, and the next cycle has `ready`=1. Counted from the rising of `pd_req_n`, `ready` rises after `SETTLE_CYCLES`+4 edges.
- R6: After synchronous reset (`rst_n` low at an edge), the block runs with `out_hold`=0, `osc_en`=`pll_en`=1, `ready`=1, and both group enables at 1.
- R7: If the request reasserts during the settling wait, the block returns to parking. `out_hold` never drops and `ready` never rises before a completed wake.
- R8: `cpu_clk_en` and `pci_clk_en` equal their stop input (active low, two-flop synchronized, 1 = run) AND NOT `out_hold`. While `out_hold` is 1, toggling the stop inputs changes no output.
- R9: `ready` is 1 only in the running state. Whenever it is 1, `osc_en` and `pll_en` are also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Internal CPU-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pd_req_n | input | 1 | Asynchronous power-down request, active low |
| cpu_stop_n | input | 1 | Asynchronous CPU clock stop, active low |
| pci_stop_n | input | 1 | Asynchronous PCI clock stop, active low |
| out_hold | output | 1 | 1 = all clock outputs parked low |
| osc_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | Synthesis loop enable |
| cpu_clk_en | output | 1 | CPU output group may toggle |
| pci_clk_en | output | 1 | Stoppable PCI output group may toggle |
| ready | output | 1 | Running with outputs released |

## Verification
The bench builds the block with `SETTLE_CYCLES` = 6 instead of the default of several hundred thousand cycles. This puts a full wake within a few dozen cycles, so the exact release edge can be counted. It also lets the bench reassert the request partway through the settling wait, before the count can finish. With two synchronizer stages, the entry latency and the one-edge filtering of the request can be checked edge by edge.

// File: rtl/clkpd_pkg.sv
// Shared types for the clock power-down sequencer.
// Assumes: a single clock domain for the sequencing logic (clk_int).
package clkpd_pkg;

    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_PARK     = 3'd1,
        ST_OSC_OFF  = 3'd2,
        ST_DOWN     = 3'd3,
        ST_WAKE     = 3'd4,
        ST_RELEASE  = 3'd5
    } pd_state_t;

endpackage

// File: rtl/clkpd_sync.sv
// Multi-bit level synchronizer: each bit passes through STAGES flops.
// Assumes: inputs are slow levels, so bits need no mutual coherence.
module clkpd_sync #(
    parameter int WIDTH = 1,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            // Shift one stage of the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg[i] <= RST_VAL;
                end else begin
                    stg[i] <= (i == 0) ? d_async : stg[(i == 0) ? 0 : i - 1];
                end
            end
        end
    endgenerate

    assign q_sync = stg[STAGES-1];

endmodule

// File: rtl/clkpd_settle.sv
// Settling timer: counts cycles while run is high and clears otherwise.
// done is high in the cycle in which the SETTLE_CYCLES-th run cycle is seen.
// Assumes: SETTLE_CYCLES >= 1.
module clkpd_settle #(
    parameter int SETTLE_CYCLES = 300000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    localparam int CW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Advance while waiting, restart from zero whenever the wait is left.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && (cnt == LAST);

endmodule

// File: rtl/clkpd_fsm.sv
// Power-down sequencing state machine.
// The synchronized request drives the transitions. The raw request re-enables
// the oscillator asynchronously in the powered-down state.
// Assumes: req_act is synchronized (1 = power-down requested).
module clkpd_fsm
    import clkpd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_act,
    input  logic req_raw_n,
    input  logic settle_done,
    output logic settle_run,
    output logic hold,
    output logic osc_en,
    output logic pll_en,
    output logic ready
);

    pd_state_t state, state_nx;

    // Next-state selection for the entry, wait and exit sequence.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:     if (req_act) state_nx = ST_PARK;
            ST_PARK:    state_nx = ST_OSC_OFF;
            ST_OSC_OFF: state_nx = ST_DOWN;
            ST_DOWN:    if (!req_act) state_nx = ST_WAKE;
            ST_WAKE: begin
                if (req_act)          state_nx = ST_PARK;
                else if (settle_done) state_nx = ST_RELEASE;
            end
            ST_RELEASE: state_nx = req_act ? ST_PARK : ST_RUN;
            default:    state_nx = ST_PARK;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // Output decode; hold reacts to the synchronized request without a state hop.
    always_comb begin
        hold       = !(state == ST_RUN || state == ST_RELEASE) || req_act;
        pll_en     = (state == ST_RUN) || (state == ST_PARK) ||
                     (state == ST_WAKE) || (state == ST_RELEASE);
        osc_en     = (state == ST_DOWN) ? req_raw_n : (state != ST_OSC_OFF);
        ready      = (state == ST_RUN);
        settle_run = (state == ST_WAKE);
    end

endmodule

// File: rtl/clkpd_seq.sv
// Clock power-down sequencer top.
// Synchronizes the power-down and stop requests, sequences the parking of the
// outputs and the oscillator/loop enables, and gates the stoppable groups.
// Assumes: clk_int runs whenever osc_en is high; the stop inputs are active low.
module clkpd_seq #(
    parameter int SETTLE_CYCLES = 300000,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk_int,
    input  logic rst_n,
    input  logic pd_req_n,
    input  logic cpu_stop_n,
    input  logic pci_stop_n,
    output logic out_hold,
    output logic osc_en,
    output logic pll_en,
    output logic cpu_clk_en,
    output logic pci_clk_en,
    output logic ready
);

    localparam int NSYNC = 3;

    logic [NSYNC-1:0] raw_in, synced;
    logic settle_run, settle_done;

    assign raw_in = {pci_stop_n, cpu_stop_n, pd_req_n};

    clkpd_sync #(
        .WIDTH  (NSYNC),
        .STAGES (SYNC_STAGES),
        .RST_VAL({NSYNC{1'b1}})
    ) u_sync (
        .clk    (clk_int),
        .rst_n  (rst_n),
        .d_async(raw_in),
        .q_sync (synced)
    );

    clkpd_settle #(
        .SETTLE_CYCLES(SETTLE_CYCLES)
    ) u_settle (
        .clk  (clk_int),
        .rst_n(rst_n),
        .run  (settle_run),
        .done (settle_done)
    );

    clkpd_fsm u_fsm (
        .clk        (clk_int),
        .rst_n      (rst_n),
        .req_act    (!synced[0]),
        .req_raw_n  (pd_req_n),
        .settle_done(settle_done),
        .settle_run (settle_run),
        .hold       (out_hold),
        .osc_en     (osc_en),
        .pll_en     (pll_en),
        .ready      (ready)
    );

    // Group gating: a stop only matters while the outputs are released.
    always_comb begin
        cpu_clk_en = synced[1] && !out_hold;
        pci_clk_en = synced[2] && !out_hold;
    end

endmodule

// File: rtl/clkpd_seq_chk.sv
// Property checker for clkpd_seq, attached with bind.
// Assumes: two synchronizer stages (default).
module clkpd_seq_chk (
    input logic clk_int,
    input logic rst_n,
    input logic pd_req_n,
    input logic out_hold,
    input logic osc_en,
    input logic pll_en,
    input logic cpu_clk_en,
    input logic pci_clk_en,
    input logic ready
);

    logic [1:0] age;

    // Count edges since reset, saturating, so history-based checks start late enough.
    always_ff @(posedge clk_int) begin
        if (!rst_n)          age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    // R2
    pll_fall_parked_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
        $fell(pll_en) |-> $past(out_hold));

    // R2
    osc_fall_parked_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
        $fell(osc_en) |-> $past(out_hold));

    // R3
    entry_latency_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
        (age == 2'd3) && !$past(pd_req_n, 2) |-> out_hold);

    // R4
    loops_off_parked_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
        !pll_en |-> out_hold);

    // R7
    ready_after_release_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
        $rose(ready) |-> $past(!out_hold));

    // R8
    groups_parked_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
        out_hold |-> (!cpu_clk_en && !pci_clk_en));

    // R9
    ready_clocks_on_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
        ready |-> (osc_en && pll_en));

endmodule

bind clkpd_seq clkpd_seq_chk u_chk (
    .clk_int   (clk_int),
    .rst_n     (rst_n),
    .pd_req_n  (pd_req_n),
    .out_hold  (out_hold),
    .osc_en    (osc_en),
    .pll_en    (pll_en),
    .cpu_clk_en(cpu_clk_en),
    .pci_clk_en(pci_clk_en),
    .ready     (ready)
);

// File: tb/clkpd_seq_test.sv
// Bench for clkpd_seq: a behavioural reference compared every cycle, plus directed checks.
module clkpd_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int SETTLE = 6;

    localparam int M_RUN = 0, M_PARK = 1, M_OFF = 2, M_DOWN = 3, M_WAKE = 4, M_REL = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_req_n = 1'b1, cpu_stop_n = 1'b1, pci_stop_n = 1'b1;
    logic out_hold, osc_en, pll_en, cpu_clk_en, pci_clk_en, ready;

    int checks = 0;
    int fails = 0;

    clkpd_seq #(.SETTLE_CYCLES(SETTLE)) uut (
        .clk_int(clk), .rst_n(rst_n), .pd_req_n(pd_req_n),
        .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
        .out_hold(out_hold), .osc_en(osc_en), .pll_en(pll_en),
        .cpu_clk_en(cpu_clk_en), .pci_clk_en(pci_clk_en), .ready(ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Reference model: queues hold the last two samples, index 0 newest.
    int mst = M_RUN;
    int mcnt = 0;
    bit rq[$] = '{1'b1, 1'b1};
    bit cq[$] = '{1'b1, 1'b1};
    bit pq[$] = '{1'b1, 1'b1};

    always @(posedge clk) begin
        if (!rst_n) begin
            mst = M_RUN; mcnt = 0;
            rq = '{1'b1, 1'b1}; cq = '{1'b1, 1'b1}; pq = '{1'b1, 1'b1};
        end else begin
            bit want_down;
            want_down = !rq[1];
            case (mst)
                M_RUN:  if (want_down) mst = M_PARK;
                M_PARK: mst = M_OFF;
                M_OFF:  mst = M_DOWN;
                M_DOWN: if (!want_down) begin mst = M_WAKE; mcnt = 0; end
                M_WAKE: begin
                    if (want_down) mst = M_PARK;
                    else if (mcnt == SETTLE - 1) mst = M_REL;
                    else mcnt++;
                end
                default: mst = want_down ? M_PARK : M_RUN;
            endcase
            rq.push_front(pd_req_n); void'(rq.pop_back());
            cq.push_front(cpu_stop_n); void'(cq.pop_back());
            pq.push_front(pci_stop_n); void'(pq.pop_back());
        end
    end

    // Compare every output against the model shortly after each falling edge.
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            logic e_hold, e_osc, e_pll;
            e_hold = !(mst == M_RUN || mst == M_REL) || !rq[1];
            e_pll  = (mst == M_RUN || mst == M_PARK || mst == M_WAKE || mst == M_REL);
            e_osc  = (mst == M_DOWN) ? pd_req_n : (mst != M_OFF);
            chk("R3", "out_hold", out_hold, e_hold);
            chk("R2", "pll_en", pll_en, e_pll);
            chk("R4", "osc_en", osc_en, e_osc);
            chk("R9", "ready", ready, logic'(mst == M_RUN));
            chk("R8", "cpu_clk_en", cpu_clk_en, !e_hold && cq[1]);
            chk("R8", "pci_clk_en", pci_clk_en, !e_hold && pq[1]);
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wake_and_count(input string req);
        int n;
        pd_req_n = 1'b1;
        n = 0;
        do begin tick(1); n++; #2; end while (!ready && n < 60);
        chk(req, "edges to ready", logic'(n == SETTLE + 4), 1'b1);
        if (n != SETTLE + 4) $display("  edges actual=%0d expected=%0d", n, SETTLE + 4);
    endtask

    initial begin
        bit released;
        tick(3);
        rst_n = 1'b1;
        tick(1); #2;
        // R6 reset state
        chk("R6", "hold", out_hold, 1'b0);
        chk("R6", "ready", ready, 1'b1);
        chk("R6", "osc_en", osc_en, 1'b1);
        chk("R6", "pll_en", pll_en, 1'b1);
        chk("R6", "cpu_clk_en", cpu_clk_en, 1'b1);

        // R8 stop passes through two flops while running
        tick(1); cpu_stop_n = 1'b0;
        tick(1); #2; chk("R8", "cpu_en after 1 edge", cpu_clk_en, 1'b1);
        tick(1); #2; chk("R8", "cpu_en after 2 edges", cpu_clk_en, 1'b0);
        chk("R8", "pci_en untouched", pci_clk_en, 1'b1);
        cpu_stop_n = 1'b1; pci_stop_n = 1'b0;
        tick(3); #2; chk("R8", "pci_en stopped", pci_clk_en, 1'b0);
        pci_stop_n = 1'b1;
        tick(3);

        // Entry sequence
        pd_req_n = 1'b0;
        tick(1); #2; chk("R1", "hold after 1 edge", out_hold, 1'b0);
        tick(1); #2; chk("R3", "hold after 2 edges", out_hold, 1'b1);
        tick(1); #2; chk("R2", "pll still on in park", pll_en, 1'b1);
        chk("R2", "osc still on in park", osc_en, 1'b1);
        tick(1); #2; chk("R2", "pll off", pll_en, 1'b0);
        chk("R2", "osc off", osc_en, 1'b0);
        tick(3);

        // Stops toggled while powered down have no effect
        cpu_stop_n = 1'b0; pci_stop_n = 1'b0;
        tick(3); #2; chk("R8", "cpu_en while down", cpu_clk_en, 1'b0);
        cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
        tick(3); #2; chk("R8", "pci_en while down", pci_clk_en, 1'b0);
        chk("R4", "hold while down", out_hold, 1'b1);

        // Asynchronous wake: osc_en follows the raw request without an edge
        pd_req_n = 1'b1; #1;
        chk("R4", "osc_en async wake", osc_en, 1'b1);
        pd_req_n = 1'b0; #1;
        chk("R4", "osc_en follows raw low", osc_en, 1'b0);
        tick(2);
        wake_and_count("R5");
        tick(4);

        // Re-request during the settling wait
        pd_req_n = 1'b0;
        tick(10);
        pd_req_n = 1'b1;
        tick(5);
        pd_req_n = 1'b0;
        released = 1'b0;
        for (int i = 0; i < 20; i++) begin
            tick(1); #2;
            if (!out_hold || ready) released = 1'b1;
        end
        chk("R7", "never released", released, 1'b0);
        wake_and_count("R5");
        tick(5);
        finish_run();
    end

endmodule